// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block takes one vectored maskable interrupt line and three assigned-vector interrupt lines, and picks the request to serve. It runs the acknowledge cycle on the I/O bus strobes, asks the CPU to push the return address, and builds the 32-bit address of the vector table entry. It then reads the new program counter through a word-wide memory read port and hands the result to the CPU. A vectored request takes its table offset from a 16-bit vector that the acknowledged device drives. An assigned request takes a fixed per-line offset, placed under a programmable 7-bit base and the upper 16-bit page. The table entry is one word in narrow mode and two words in wide mode.

Two enable flags gate all requests. A pulse on `enable_set` sets both flags while the block is idle. Taking a request clears both flags. The memory request, memory response and program-counter outputs are valid/ready streams. A producer keeps valid and its payload steady until ready is seen at a clock edge. `rsp_ready` is high only in the cycles in which the block waits for a read word, and `rsp_valid` is ignored in every other cycle. The strobes, the push handshake and the flags are plain level signals.

Top module: `irq_vector_seq`

## Requirements
- R1: During reset and just after it, both enable flags are 0, and every strobe, `push_req`, `rd_valid`, `rsp_ready` and `pc_valid` is 0.
- R2: While the block is idle and the flags are clear, requests are ignored and no strobe is raised. An `enable_set` pulse while idle sets both flags from the next cycle on.
- R3: When several requests are pending at once, the vectored line wins over assigned line 1, then line 2, then line 3.
- R4: Both flags read 0 from the cycle after a request is taken. An `enable_set` pulse while the block is busy has no effect.
- R5: A vectored acknowledge raises `bus_opfetch` and `bus_io_req` until `bus_ready`. In that same edge the block captures `bus_vector` with bit 0 forced to 0.
- R6: An assigned acknowledge raises only `bus_int_ack` until `bus_ready`. `bus_io_read` and `bus_io_write` are never raised.
- R7: After the acknowledge, `push_req` stays high until `push_done`. `push_two` is 1 when the request was taken in wide mode.
- R8: A vectored table address is {page[15:0], vector[15:1], 0}.
- R9: An assigned table address is {page[15:0], base[6:0], offset[8:0]}, with offset 0x000 for line 1, 0x004 for line 2 and 0x008 for line 3.
- R10: In narrow mode one word is read, and `pc_value` = {16'h0000, word}.
- R11: In wide mode the low word is read at the table address and the high word at the table address + 2, with a full 32-bit carry. `pc_value` = {high, low} and is offered only after both reads.
- R12: `rd_valid` and `rd_addr` hold until `rd_ready`. `pc_valid` and `pc_value` hold until `pc_ready`.
- R13: The page, the base and the mode are sampled when a request is taken. Changes to them during service do not alter that service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vectored | input | 1 | Vectored interrupt request (level) |
| req_assigned | input | 3 | Assigned requests, bit 0 = line 1 |
| enable_set | input | 1 | Pulse that sets both enable flags |
| en_flag1 | output | 1 | Enable flag 1 |
| en_flag2 | output | 1 | Enable flag 2 |
| wide_mode | input | 1 | 1 = two-word table entries |
| ext_page | input | 16 | Upper 16 address bits of the table |
| assign_base | input | 7 | Base field for assigned lines |
| bus_opfetch | output | 1 | Opcode-fetch strobe |
| bus_io_req | output | 1 | I/O-request strobe |
| bus_io_read | output | 1 | I/O-read strobe (held low) |
| bus_io_write | output | 1 | I/O-write strobe (held low) |
| bus_int_ack | output | 1 | Interrupt-acknowledge strobe |
| bus_ready | input | 1 | Acknowledge cycle complete |
| bus_vector | input | 16 | Device-supplied vector |
| push_req | output | 1 | Request to push the return address |
| push_two | output | 1 | Push two words instead of one |
| push_done | input | 1 | Push finished |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | 32 | Memory read byte address |
| rsp_valid | input | 1 | Read word valid |
| rsp_ready | output | 1 | Block awaits a read word |
| rsp_data | input | 16 | Read word |
| pc_valid | output | 1 | New program counter valid |
| pc_ready | input | 1 | New program counter taken |
| pc_value | output | 32 | New program counter |

## Verification
Every output is decoded from registered state, so a wrong internal state shows up at the ports in the first cycle it exists. A wrong winner or phase shows on the strobes during the acknowledge cycle, or on `rd_addr` as soon as the fetch starts. A corrupted latched page, base or mode shows as a wrong address or a wrong `push_two` several cycles before the program counter appears. Flag errors show on `en_flag1` and `en_flag2` one cycle after the faulty edge. The bench model is compared with every output on every clock, so any divergence is reported in the cycle it appears.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK,
    S_PUSH,
    S_RD_LO,
    S_WT_LO,
    S_RD_HI,
    S_WT_HI,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_ASG = 3,
  localparam int SEL_W = $clog2(N_ASG + 1)
) (
  input  logic             vec_req,
  input  logic [N_ASG-1:0] asg_req,
  output logic             any_req,
  output logic [SEL_W-1:0] sel
);
  // sel 0 = vectored line, sel k = assigned line k
  always_comb begin
    any_req = vec_req | (|asg_req);
    sel = '0;
    for (int i = N_ASG - 1; i >= 0; i--) begin
      if (asg_req[i]) sel = SEL_W'(i + 1);
    end
    if (vec_req) sel = '0;
  end

  always_comb begin
    if (vec_req) assert (sel == '0) else $error("AST_VEC_FIRST"); // R3
  end
endmodule

// File: rtl/irq_tbl_addr.sv
module irq_tbl_addr #(
  parameter int WORD_W   = 16,
  parameter int BASE_W   = 7,
  parameter int N_ASG    = 3,
  parameter int OFS_STEP = 4,
  localparam int ADDR_W = 2 * WORD_W,
  localparam int OFS_W  = WORD_W - BASE_W,
  localparam int SEL_W  = $clog2(N_ASG + 1)
) (
  input  logic [WORD_W-1:0] page,
  input  logic [BASE_W-1:0] base,
  input  logic [WORD_W-1:0] vec,
  input  logic [SEL_W-1:0]  sel,
  input  logic              upper,
  output logic [ADDR_W-1:0] addr
);
  logic [OFS_W-1:0]  ofs_tab [N_ASG+1];
  logic [ADDR_W-1:0] entry;

  for (genvar g = 0; g <= N_ASG; g++) begin : g_ofs
    if (g == 0) begin : g_none
      assign ofs_tab[g] = '0;
    end else begin : g_line
      assign ofs_tab[g] = OFS_W'((g - 1) * OFS_STEP);
    end
  end

  always_comb begin
    if (sel == '0) entry = {page, vec};
    else           entry = {page, base, ofs_tab[sel]};
    addr = entry + {{(ADDR_W-2){1'b0}}, upper, 1'b0};
  end
endmodule

// File: rtl/irq_pc_asm.sv
module irq_pc_asm #(
  parameter int WORD_W = 16,
  localparam int ADDR_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic [WORD_W-1:0] word,
  input  logic              wide,
  output logic [ADDR_W-1:0] pc
);
  logic [WORD_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= word;
      if (cap_hi) hi_q <= word;
    end
  end

  assign pc = wide ? {hi_q, lo_q} : {{WORD_W{1'b0}}, lo_q};

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |-> !cap_hi) else $error("AST_ONE_CAPTURE"); // R11
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq #(
  parameter int WORD_W   = 16,
  parameter int BASE_W   = 7,
  parameter int N_ASG    = 3,
  parameter int OFS_STEP = 4,
  localparam int ADDR_W = 2 * WORD_W,
  localparam int SEL_W  = $clog2(N_ASG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vectored,
  input  logic [N_ASG-1:0]  req_assigned,
  input  logic              enable_set,
  output logic              en_flag1,
  output logic              en_flag2,
  input  logic              wide_mode,
  input  logic [WORD_W-1:0] ext_page,
  input  logic [BASE_W-1:0] assign_base,
  output logic              bus_opfetch,
  output logic              bus_io_req,
  output logic              bus_io_read,
  output logic              bus_io_write,
  output logic              bus_int_ack,
  input  logic              bus_ready,
  input  logic [WORD_W-1:0] bus_vector,
  output logic              push_req,
  output logic              push_two,
  input  logic              push_done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              pc_valid,
  input  logic              pc_ready,
  output logic [ADDR_W-1:0] pc_value
);
  import irq_seq_pkg::*;

  seq_state_e        st_q;
  logic [SEL_W-1:0]  sel_q, pick;
  logic              any_req, take, busy;
  logic              flag1_q, flag2_q, wide_q;
  logic [WORD_W-1:0] page_q, vec_q;
  logic [BASE_W-1:0] base_q;
  logic              cap_lo, cap_hi;

  irq_prio_pick #(.N_ASG(N_ASG)) u_pick (
    .vec_req (req_vectored),
    .asg_req (req_assigned),
    .any_req (any_req),
    .sel     (pick)
  );

  assign take = (st_q == S_IDLE) && flag1_q && flag2_q && any_req;
  assign busy = (st_q != S_IDLE);

  // sequencer and latched context
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sel_q   <= '0;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
      wide_q  <= 1'b0;
      page_q  <= '0;
      base_q  <= '0;
      vec_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (take) begin
            sel_q   <= pick;
            wide_q  <= wide_mode;
            page_q  <= ext_page;
            base_q  <= assign_base;
            flag1_q <= 1'b0;
            flag2_q <= 1'b0;
            st_q    <= S_ACK;
          end else if (enable_set) begin
            flag1_q <= 1'b1;
            flag2_q <= 1'b1;
          end
        end
        S_ACK: begin
          if (bus_ready) begin
            if (sel_q == '0) vec_q <= bus_vector & ~{{(WORD_W-1){1'b0}}, 1'b1};
            st_q <= S_PUSH;
          end
        end
        S_PUSH:  if (push_done) st_q <= S_RD_LO;
        S_RD_LO: if (rd_ready)  st_q <= S_WT_LO;
        S_WT_LO: if (rsp_valid) st_q <= wide_q ? S_RD_HI : S_DONE;
        S_RD_HI: if (rd_ready)  st_q <= S_WT_HI;
        S_WT_HI: if (rsp_valid) st_q <= S_DONE;
        S_DONE:  if (pc_ready)  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  irq_tbl_addr #(
    .WORD_W(WORD_W), .BASE_W(BASE_W), .N_ASG(N_ASG), .OFS_STEP(OFS_STEP)
  ) u_addr (
    .page  (page_q),
    .base  (base_q),
    .vec   (vec_q),
    .sel   (sel_q),
    .upper (st_q == S_RD_HI),
    .addr  (rd_addr)
  );

  assign cap_lo = (st_q == S_WT_LO) && rsp_valid;
  assign cap_hi = (st_q == S_WT_HI) && rsp_valid;

  irq_pc_asm #(.WORD_W(WORD_W)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_lo (cap_lo),
    .cap_hi (cap_hi),
    .word   (rsp_data),
    .wide   (wide_q),
    .pc     (pc_value)
  );

  assign en_flag1     = flag1_q;
  assign en_flag2     = flag2_q;
  assign bus_opfetch  = (st_q == S_ACK) && (sel_q == '0);
  assign bus_io_req   = (st_q == S_ACK) && (sel_q == '0);
  assign bus_int_ack  = (st_q == S_ACK) && (sel_q != '0);
  assign bus_io_read  = 1'b0;
  assign bus_io_write = 1'b0;
  assign push_req     = (st_q == S_PUSH);
  assign push_two     = wide_q;
  assign rd_valid     = (st_q == S_RD_LO) || (st_q == S_RD_HI);
  assign rsp_ready    = (st_q == S_WT_LO) || (st_q == S_WT_HI);
  assign pc_valid     = (st_q == S_DONE);

  AST_INTACK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_int_ack |-> !bus_opfetch && !bus_io_req && !bus_io_read && !bus_io_write) else $error("AST_INTACK_ALONE"); // R6
  AST_FLAGS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !en_flag1 && !en_flag2) else $error("AST_FLAGS_DROP"); // R4
  AST_SET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && enable_set |=> !en_flag1 && !en_flag2) else $error("AST_SET_IGNORED"); // R4
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_done |=> push_req && $stable(push_two)) else $error("AST_PUSH_HOLD"); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)) else $error("AST_RD_HOLD"); // R12
  AST_RD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_addr[0]) else $error("AST_RD_EVEN"); // R8
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid && !pc_ready |=> pc_valid && $stable(pc_value)) else $error("AST_PC_HOLD"); // R12
endmodule

// File: tb/irq_vector_seq_bench.sv
module irq_vector_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vectored = 1'b0;
  logic [2:0]  req_assigned = '0;
  logic        enable_set = 1'b0;
  logic        en_flag1, en_flag2;
  logic        wide_mode = 1'b0;
  logic [15:0] ext_page = 16'h0000;
  logic [6:0]  assign_base = '0;
  logic        bus_opfetch, bus_io_req, bus_io_read, bus_io_write, bus_int_ack;
  logic        bus_ready = 1'b0;
  logic [15:0] bus_vector = 16'h0000;
  logic        push_req, push_two;
  logic        push_done = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [15:0] rsp_data = 16'h0000;
  logic        pc_valid;
  logic        pc_ready = 1'b0;
  logic [31:0] pc_value;

  always #10 clk = ~clk;

  irq_vector_seq u_irq_vector_seq (.*);

  int vectors = 0, miscompares = 0, cyc = 0;
  bit started = 0, finished = 0;

  // behavioural reference state
  int m_state = 0, m_src = 0;
  bit m_ief = 0, m_wide = 0, m_multi = 0;
  logic [15:0] m_page = 0, m_vec = 0, m_lo = 0, m_hi = 0;
  logic [6:0]  m_base = 0;

  // responder state
  bit rd_fire = 0, rsp_fire = 0, pend = 0;
  logic [31:0] paddr = 0;
  int lat = 0, ack_cnt = 0, push_cnt = 0;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [15:0] mem_word(logic [31:0] a);
    logic [15:0] p = a[15:0] * 16'h9E37;
    return p ^ a[31:16] ^ 16'h5A5A;
  endfunction

  function automatic logic [31:0] table_addr(int src, logic [15:0] pg, logic [6:0] b, logic [15:0] v);
    if (src == 0) return {pg, v};
    return {pg, b, 9'((src - 1) * 4)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // reference model and handshake capture at the clock edge
  always @(posedge clk) begin
    cyc++;
    started = 1;
    rd_fire  = rd_fire  | (rd_valid && rd_ready);
    rsp_fire = rsp_fire | (rsp_valid && rsp_ready);
    if (rd_valid && rd_ready) paddr = rd_addr;
    if (!rst_n) begin
      m_state = 0; m_ief = 0;
    end else begin
      case (m_state)
        0: if (m_ief && (req_vectored || req_assigned != 0)) begin
             if (req_vectored) m_src = 0;
             else if (req_assigned[0]) m_src = 1;
             else if (req_assigned[1]) m_src = 2;
             else m_src = 3;
             m_multi = ($countones({req_vectored, req_assigned}) > 1);
             m_ief = 0; m_wide = wide_mode; m_page = ext_page; m_base = assign_base;
             m_state = 1;
           end else if (enable_set) m_ief = 1;
        1: if (bus_ready) begin
             if (m_src == 0) m_vec = bus_vector & 16'hFFFE;
             m_state = 2;
           end
        2: if (push_done) m_state = 3;
        3: if (rd_ready) m_state = 4;
        4: if (rsp_valid) begin m_lo = rsp_data; m_state = m_wide ? 5 : 7; end
        5: if (rd_ready) m_state = 6;
        6: if (rsp_valid) begin m_hi = rsp_data; m_state = 7; end
        default: if (pc_ready) m_state = 0;
      endcase
    end
    if (cyc > 20000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // comparison, then responders
  always @(negedge clk) begin
    string ta, ts;
    logic [31:0] ea;
    if (started && !finished) begin
      ta = !rst_n ? "R1" : "R4";
      chk(ta, en_flag1, m_ief);
      chk(ta, en_flag2, m_ief);
      ts = !rst_n ? "R1" : (m_state == 0) ? "R2" : (m_src == 0) ? "R5" : "R6";
      chk(ts, bus_opfetch, m_state == 1 && m_src == 0);
      chk(ts, bus_io_req,  m_state == 1 && m_src == 0);
      chk(ts, bus_int_ack, m_state == 1 && m_src != 0);
      chk("R6", bus_io_read, 0);
      chk("R6", bus_io_write, 0);
      chk(!rst_n ? "R1" : "R7", push_req, m_state == 2);
      if (m_state == 2) chk("R7", push_two, m_wide);
      chk(!rst_n ? "R1" : "R12", rd_valid, m_state == 3 || m_state == 5);
      chk(!rst_n ? "R1" : "R12", rsp_ready, m_state == 4 || m_state == 6);
      chk(!rst_n ? "R1" : "R12", pc_valid, m_state == 7);
      if (rst_n && (m_state == 3 || m_state == 5)) begin
        ea = table_addr(m_src, m_page, m_base, m_vec) + ((m_state == 5) ? 32'd2 : 32'd0);
        if (m_state == 5) ts = "R11";
        else if (m_multi) ts = "R3";
        else if (m_page != ext_page || m_base != assign_base) ts = "R13";
        else ts = (m_src == 0) ? "R8" : "R9";
        chk(ts, rd_addr, ea);
      end
      if (rst_n && m_state == 7)
        chk(m_wide ? "R11" : "R10", pc_value, m_wide ? {m_hi, m_lo} : {16'h0, m_lo});
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (!(bus_opfetch || bus_int_ack)) begin ack_cnt = int'(lf[1:0]); bus_ready = 0; end
    else if (ack_cnt != 0) begin ack_cnt--; bus_ready = 0; end
    else bus_ready = 1;
    if (!push_req) begin push_cnt = int'(lf[6:5]); push_done = 0; end
    else if (push_cnt != 0) begin push_cnt--; push_done = 0; end
    else push_done = 1;
    rd_ready = rd_valid && lf[2];
    if (rsp_fire) begin pend = 0; rsp_valid = 0; rsp_fire = 0; end
    if (rd_fire) begin pend = 1; lat = int'(lf[4:3]); rd_fire = 0; end
    if (pend) begin
      if (lat != 0) lat--;
      else begin rsp_valid = 1; rsp_data = mem_word(paddr); end
    end
    pc_ready = pc_valid && lf[7];
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_enable();
    tick(1); enable_set = 1;
    tick(1); enable_set = 0;
  endtask

  // wait for acceptance, drop the served line, optionally disturb, wait for idle
  task automatic serve(bit disturb);
    while (m_state == 0) tick(1);
    if (m_src == 0) req_vectored = 0; else req_assigned[m_src-1] = 0;
    if (disturb) begin
      while (m_state < 3) tick(1);
      ext_page = ~ext_page; assign_base = ~assign_base; wide_mode = ~wide_mode;
      enable_set = 1; tick(1); enable_set = 0;   // R4: ignored while busy
    end
    while (m_state != 0) tick(1);
    tick(2);
  endtask

  initial begin
    tick(4);
    rst_n = 1;
    tick(2);
    // R2: request ignored while flags are clear
    req_assigned = 3'b001; ext_page = 16'h1357; assign_base = 7'h2A;
    tick(6);
    pulse_enable();
    serve(0);                                   // R9 line 1, narrow (R10)
    bus_vector = 16'h1235; req_vectored = 1;    // R5, R8 odd vector aligned
    pulse_enable(); serve(0);
    wide_mode = 1; req_assigned = 3'b010;       // R11 wide, line 2
    pulse_enable(); serve(0);
    wide_mode = 0; req_assigned = 3'b100;       // line 3 narrow
    pulse_enable(); serve(0);
    // R3: all pending, served in priority order
    req_vectored = 1; req_assigned = 3'b111; bus_vector = 16'h0F0E;
    for (int k = 0; k < 4; k++) begin
      wide_mode = k[0];
      pulse_enable();
      serve(k == 2);                            // R13 disturbance mid-service
    end
    // R11 carry into page: vector 0xFFFF, wide
    ext_page = 16'h00FF; wide_mode = 1; bus_vector = 16'hFFFF; req_vectored = 1;
    pulse_enable(); serve(0);
    req_assigned = 3'b001; ext_page = 16'hFFFF; assign_base = 7'h7F;
    pulse_enable(); serve(1);
    tick(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule